// File: doc/BRIEF.md
# Sampling Ring Trigger-Stop Readout Controller

This block sequences a circular switched-capacitor sampling array, modelled here as a write pointer that runs around a ring of cells. The ring length is set by a cascade mode. Mode m joins 2^m base rings of `2^BASE_W` cells into one longer ring. With the defaults, the four modes give 8 rings of 1024 cells, 4 of 2048, 2 of 4096 or 1 of 8192.

An accepted trigger does not freeze sampling at once. It starts a programmable countdown. When the countdown expires, the write pointer stops and its value is latched as the stop cell. The block then reads out a region of interest. This is a programmable number of samples that starts at the stop cell and wraps around the ring. Each sample is paced by a readout clock enable, and the cell index of each sample is emitted with it for later per-cell correction. After the final sample the block signals completion, resumes sampling and waits for the next trigger.

Top module: `sca_stop_ctrl`

## Requirements
- R1: In idle, the write pointer `wr_ptr_o` advances by one every clock. It wraps to 0 after cell `(2^BASE_W << mode_i) - 1`. If a pointer value is beyond the end of a newly selected ring, it returns to 0 on the next edge.
- R2: A trigger is accepted on the edge where `trig_i` is high in idle. Counting that edge as edge 0, the pointer advances on edges 1 to `delay_i`, holds from edge `delay_i+1`, and `stop_idx_o` takes the frozen value on that same edge. `stop_idx_o` keeps this value until the next stop.
- R3: The write pointer holds its value from the stop until the block is idle again. It then advances as in R1.
- R4: During readout, each clock with `rd_ce_i` high produces a one-cycle `smp_vld_o` pulse in the next cycle. The first `smp_idx_o` equals `stop_idx_o`, and each later one is the previous value plus one, modulo the ring length. No sample is produced while `rd_ce_i` is low.
- R5: The number of samples equals `roi_i` at trigger time. A value of 0, or a value above the ring length, gives exactly one full ring.
- R6: `trig_i` has no effect while `busy_o` is high. The stop cell, the sample count and the index stream are unchanged.
- R7: `busy_o` goes high the cycle after the accepted trigger. It stays high through the cycle in which `done_o` is high, and is low in the following cycle.
- R8: `done_o` is high for exactly one cycle, and that cycle is the one carrying the final `smp_vld_o`.
- R9: While `rst_ni` is low, `wr_ptr_o`, `stop_idx_o`, `smp_idx_o`, `smp_vld_o`, `busy_o` and `done_o` are all 0.
- R10: `mode_i`, `delay_i` and `roi_i` are sampled at the accepted trigger. Changing them while busy does not alter that acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger request |
| mode_i | input | MODE_W | Cascade mode, ring length `2^BASE_W << mode_i` |
| delay_i | input | DLY_W | Trigger-to-stop delay in clocks |
| roi_i | input | IDX_W+1 | Region-of-interest length in samples |
| rd_ce_i | input | 1 | Readout clock enable, one sample per high cycle |
| wr_ptr_o | output | IDX_W | Current write cell |
| sampling_o | output | 1 | Array is sampling (idle or in delay) |
| stop_idx_o | output | IDX_W | Latched stop cell |
| smp_vld_o | output | 1 | Sample address valid |
| smp_idx_o | output | IDX_W | Ring cell index of the current sample |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | Last sample delivered |

## Verification
The bench builds the block with `BASE_W=4`, `MAX_CASC=3` and `DLY_W=8`, which gives rings of 16, 32, 64 and 128 cells. With rings this short, the write pointer wraps many times during idle gaps and delay windows. Regions of interest that wrap past the end of the ring, full-ring readouts, clamped lengths, and shrinking the ring while the pointer sits beyond its new end are all reachable within a few hundred cycles. Stalled readout enables, trigger pulses during busy, and configuration changes during busy are applied alongside the cycle-accurate model.

// File: rtl/sca_ctrl_pkg.sv
package sca_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } ctrl_st_e;
endpackage

// File: rtl/sca_ring_ptr.sv
module sca_ring_ptr #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W:0]   len_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] ptr_q;
  logic [W:0]   inc;

  assign inc = {1'b0, ptr_q} + {{W{1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (load_i)  ptr_q <= load_val_i;
    else if (adv_i)   ptr_q <= (inc >= len_i) ? '0 : inc[W-1:0];
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/sca_delay_cnt.sv
module sca_delay_cnt #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dly_i,
  input  logic          run_i,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= dly_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/sca_roi_cnt.sv
module sca_roi_cnt #(
  parameter int LW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic          tick_i,
  output logic          last_o
);
  logic [LW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_i)  rem_q <= len_i;
    else if (tick_i)  rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == LW'(1));
endmodule

// File: rtl/sca_stop_ctrl.sv
module sca_stop_ctrl
  import sca_ctrl_pkg::*;
#(
  parameter int BASE_W   = 10,
  parameter int MAX_CASC = 3,
  parameter int DLY_W    = 16,
  parameter int MODE_W   = 2,
  localparam int IDX_W   = BASE_W + MAX_CASC,
  localparam int LEN_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [LEN_W-1:0]  roi_i,
  input  logic              rd_ce_i,
  output logic [IDX_W-1:0]  wr_ptr_o,
  output logic              sampling_o,
  output logic [IDX_W-1:0]  stop_idx_o,
  output logic              smp_vld_o,
  output logic [IDX_W-1:0]  smp_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int N_MODES = 2 ** MODE_W;

  // ring length per mode; codes above MAX_CASC use the longest ring
  logic [LEN_W-1:0] len_tab [N_MODES];
  for (genvar g = 0; g < N_MODES; g++) begin : g_len
    if (g <= MAX_CASC) begin : g_ok
      assign len_tab[g] = LEN_W'(1) << (BASE_W + g);
    end else begin : g_sat
      assign len_tab[g] = LEN_W'(1) << IDX_W;
    end
  end

  ctrl_st_e          st_q, st_d;
  logic [MODE_W-1:0] mode_q;
  logic [LEN_W-1:0]  roi_q;
  logic [IDX_W-1:0]  stop_q, idx_q;
  logic              vld_q;

  logic [LEN_W-1:0]  live_len, run_len, wr_len, roi_eff;
  logic [IDX_W-1:0]  wr_ptr, rd_ptr;
  logic              accept, expire, wr_adv, rd_tick, roi_last;

  assign live_len = len_tab[mode_i];
  assign run_len  = len_tab[mode_q];
  assign roi_eff  = (roi_i == '0 || roi_i > live_len) ? live_len : roi_i;

  assign accept  = (st_q == ST_IDLE) && trig_i;
  assign wr_adv  = (st_q == ST_IDLE) || ((st_q == ST_WAIT) && !expire);
  assign wr_len  = (st_q == ST_IDLE) ? live_len : run_len;
  assign rd_tick = (st_q == ST_READ) && rd_ce_i;

  sca_ring_ptr #(.W(IDX_W)) u_wr_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (wr_adv),
    .load_i     (1'b0),
    .load_val_i ('0),
    .len_i      (wr_len),
    .ptr_o      (wr_ptr)
  );

  sca_ring_ptr #(.W(IDX_W)) u_rd_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (rd_tick),
    .load_i     (expire),
    .load_val_i (wr_ptr),
    .len_i      (run_len),
    .ptr_o      (rd_ptr)
  );

  sca_delay_cnt #(.DW(DLY_W)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .dly_i    (delay_i),
    .run_i    (st_q == ST_WAIT),
    .expire_o (expire)
  );

  sca_roi_cnt #(.LW(LEN_W)) u_roi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (expire),
    .len_i  (roi_q),
    .tick_i (rd_tick),
    .last_o (roi_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (trig_i)              st_d = ST_WAIT;
      ST_WAIT: if (expire)              st_d = ST_READ;
      ST_READ: if (rd_tick && roi_last) st_d = ST_DONE;
      ST_DONE:                          st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      roi_q  <= '0;
      stop_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      vld_q <= rd_tick;
      if (accept) begin
        mode_q <= mode_i;
        roi_q  <= roi_eff;
      end
      if (expire)  stop_q <= wr_ptr;
      if (rd_tick) idx_q  <= rd_ptr;
    end
  end

  assign wr_ptr_o   = wr_ptr;
  assign sampling_o = (st_q == ST_IDLE) || (st_q == ST_WAIT);
  assign stop_idx_o = stop_q;
  assign smp_vld_o  = vld_q;
  assign smp_idx_o  = idx_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
endmodule

// File: rtl/sca_stop_ctrl_chk.sv
module sca_stop_ctrl_chk #(
  parameter int IDX_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             sampling_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             smp_vld_o,
  input logic [IDX_W-1:0] smp_idx_o,
  input logic [IDX_W-1:0] stop_idx_o,
  input logic [IDX_W-1:0] wr_ptr_o,
  input logic [IDX_W:0]   run_len
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_WITH_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> smp_vld_o); // R8
  AST_DONE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R7
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(trig_i)); // R7
  AST_VLD_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_o |-> (busy_o && !sampling_o)); // R4
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_o |-> ({1'b0, smp_idx_o} < run_len)); // R4
  AST_WR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sampling_o |-> $stable(wr_ptr_o)); // R3
  AST_STOP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sampling_o && $past(!sampling_o)) |-> $stable(stop_idx_o)); // R2
endmodule

bind sca_stop_ctrl sca_stop_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_i     (trig_i),
  .sampling_o (sampling_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .smp_vld_o  (smp_vld_o),
  .smp_idx_o  (smp_idx_o),
  .stop_idx_o (stop_idx_o),
  .wr_ptr_o   (wr_ptr_o),
  .run_len    (run_len)
);

// File: tb/tb_sca_stop_ctrl.sv
module tb_sca_stop_ctrl;
  localparam int BASE_W = 4;
  localparam int MAX_CASC = 3;
  localparam int DLY_W = 8;
  localparam int MODE_W = 2;
  localparam int IDX_W = BASE_W + MAX_CASC;
  localparam int LEN_W = IDX_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0;
  logic [MODE_W-1:0] mode_i = '0;
  logic [DLY_W-1:0] delay_i = '0;
  logic [LEN_W-1:0] roi_i = '0;
  logic rd_ce_i = 1'b0;
  logic [IDX_W-1:0] wr_ptr_o, stop_idx_o, smp_idx_o;
  logic sampling_o, smp_vld_o, busy_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sca_stop_ctrl #(.BASE_W(BASE_W), .MAX_CASC(MAX_CASC), .DLY_W(DLY_W), .MODE_W(MODE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig_i), .mode_i(mode_i), .delay_i(delay_i),
    .roi_i(roi_i), .rd_ce_i(rd_ce_i), .wr_ptr_o(wr_ptr_o), .sampling_o(sampling_o),
    .stop_idx_o(stop_idx_o), .smp_vld_o(smp_vld_o), .smp_idx_o(smp_idx_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rlen(input int m);
    return 16 << m;
  endfunction

  function automatic int step(input int p, input int len);
    return (p + 1 >= len) ? 0 : p + 1;
  endfunction

  // behavioural reference, one update per rising edge
  int m_st = 0, m_wr = 0, m_mode = 0, m_cnt = 0, m_rem = 0, m_rd = 0;
  int m_stop = 0, m_idx = 0;
  bit m_vld = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_wr = 0; m_mode = 0; m_cnt = 0; m_rem = 0; m_rd = 0;
      m_stop = 0; m_idx = 0; m_vld = 0;
    end else begin
      m_vld = 0;
      case (m_st)
        0: begin
          m_wr = step(m_wr, rlen(mode_i));
          if (trig_i) begin
            m_mode = mode_i;
            m_rem = (roi_i == 0 || roi_i > rlen(mode_i)) ? rlen(mode_i) : roi_i;
            m_cnt = delay_i;
            m_st = 1;
          end
        end
        1: begin
          if (m_cnt == 0) begin
            m_stop = m_wr; m_rd = m_wr; m_st = 2;
          end else begin
            m_cnt--; m_wr = step(m_wr, rlen(m_mode));
          end
        end
        2: if (rd_ce_i) begin
          m_vld = 1; m_idx = m_rd; m_rd = step(m_rd, rlen(m_mode)); m_rem--;
          if (m_rem == 0) m_st = 3;
        end
        default: m_st = 0;
      endcase
    end
  end

  // per-run observation
  int vld_cnt = 0, done_cnt = 0, first_idx = -1;
  bit done_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(wr_ptr_o == m_wr, "R1/R3 wr_ptr", wr_ptr_o, m_wr);
      chk(stop_idx_o == m_stop, "R2 stop_idx", stop_idx_o, m_stop);
      chk(busy_o == (m_st != 0), "R7 busy", busy_o, m_st != 0);
      chk(done_o == (m_st == 3), "R8 done", done_o, m_st == 3);
      chk(smp_vld_o == m_vld, "R4 smp_vld", smp_vld_o, m_vld);
      if (m_vld) chk(smp_idx_o == m_idx, "R4 smp_idx", smp_idx_o, m_idx);
      if (smp_vld_o) begin
        if (vld_cnt == 0) first_idx = smp_idx_o;
        vld_cnt++;
      end
      if (done_o) begin
        done_cnt++;
        done_seen = 1;
      end
    end
  end

  task automatic drive_wait();
    @(posedge clk);
    #5;
  endtask

  task automatic run(input int mode, input int dly, input int roi, input bit half_ce,
                     input bit noise, input string tag);
    int exp_n;
    exp_n = (roi == 0 || roi > rlen(mode)) ? rlen(mode) : roi;
    vld_cnt = 0; done_cnt = 0; first_idx = -1; done_seen = 0;
    mode_i = MODE_W'(mode); delay_i = DLY_W'(dly); roi_i = LEN_W'(roi);
    trig_i = 1'b1;
    drive_wait();
    trig_i = 1'b0;
    for (int k = 0; k < 2000 && !done_seen; k++) begin
      rd_ce_i = half_ce ? k[0] : 1'b1;
      if (noise && k >= 2 && k <= 5) begin
        trig_i = 1'b1;                      // R6 / R10 disturbance
        mode_i = MODE_W'((mode + 1) % 4);
        roi_i = LEN_W'(3);
        delay_i = DLY_W'(1);
      end else begin
        trig_i = 1'b0;
      end
      drive_wait();
    end
    trig_i = 1'b0;
    rd_ce_i = 1'b0;
    drive_wait();
    chk(vld_cnt == exp_n, {"R5 sample count ", tag}, vld_cnt, exp_n);
    chk(first_idx == int'(stop_idx_o), {"R4 first index ", tag}, first_idx, stop_idx_o);
    chk(done_cnt == 1, {"R8 done pulses ", tag}, done_cnt, 1);
    if (noise) chk(vld_cnt == exp_n, {"R6 R10 trigger ignored ", tag}, vld_cnt, exp_n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #15;
    chk(wr_ptr_o == 0 && stop_idx_o == 0 && smp_idx_o == 0, "R9 reset idx", wr_ptr_o, 0);
    chk(!busy_o && !done_o && !smp_vld_o, "R9 reset flags", busy_o | done_o | smp_vld_o, 0);
    #20 rst_n = 1'b1;
    drive_wait();
    // R1: let the idle pointer wrap in mode 0
    repeat (40) drive_wait();
    run(0, 3, 5, 0, 0, "m0");
    repeat (7) drive_wait();
    run(1, 2, 0, 1, 1, "m1 roi0 noise");
    run(3, 0, 200, 0, 0, "m3 clamp");
    repeat (13) drive_wait();
    run(2, 20, 64, 1, 0, "m2 full");
    // R1: shrink the ring while the pointer sits high
    mode_i = 2'd3;
    repeat (100) drive_wait();
    mode_i = 2'd0;
    repeat (3) drive_wait();
    run(0, 9, 16, 0, 0, "m0 full");
    run(1, 5, 31, 1, 0, "m1 wrap");
    repeat (5) drive_wait();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule